// File: doc/BRIEF.md
# Snoop Inquire Address Tracker

This block sits on the system side of a bus that is shared with a cached processor. When system logic runs a snoop (inquire) cycle, the block captures the cache-line address from the processor address bus as the snoop strobe is asserted. It checks that address against its even-parity bit and reports any mismatch. It then watches the modified-hit response. When the processor answers a modified hit with a writeback, the block presents the address that system logic must use for that writeback.

The source of that address depends on the address-hold signal. If address hold stayed asserted from the snoop through the writeback strobe, the processor is not driving the bus, so the block uses the copy it latched at the snoop. If address hold was released at any point, the block takes the address from the bus in the cycle the processor asserts its address strobe. In both cases the result is a 32-byte aligned address. While the address-mask input is active, one configured bit of that address (bit 20 by default) is cleared. The latched copy is in place long before the earliest legal writeback strobe, which can come two clocks after the modified hit.

Top module: `snoop_wb_tracker`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `par_err`, `proto_err`, `wb_valid`, `wb_addr`, the latched address and the pending state.
- R2: An accepted snoop strobe raises `par_err` for exactly the next cycle when the XOR of `bus_addr[31:5]` and `addr_par` is 1 (even parity violated). When that XOR is 0, `par_err` stays low.
- R3: `wb_addr[4:0]` is always zero, because writeback addresses are 32-byte line starts.
- R4: If `addr_hold` is high in the cycle a snoop is accepted, and stays high every cycle up to and including the writeback address strobe, `wb_addr[31:5]` equals the address latched at that snoop. Whatever is on `bus_addr` during the writeback strobe has no effect.
- R5: If `addr_hold` is low in any cycle between the accepted snoop and the writeback address strobe (inclusive), `wb_addr[31:5]` equals `bus_addr` as sampled in the address-strobe cycle.
- R6: When `mask_a20` is high in the address-strobe cycle, bit 20 of `wb_addr` is 0. When it is low, bit 20 follows the selected address.
- R7: `wb_valid` is high for exactly the one cycle after the first `addr_strobe` that follows a `mod_hit`. An `addr_strobe` with no modified hit pending produces no pulse.
- R8: A writeback strobe asserted two clocks after `mod_hit` is served correctly from the latched address.
- R9: A snoop strobe that arrives while a writeback is pending is ignored. The latched address is unchanged, no parity check is made, and `proto_err` is high for the next cycle.
- R10: Only the first address strobe after a modified hit completes the writeback. Later strobes produce no `wb_valid` until another `mod_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 27 | Processor address bus, bits 31:5 |
| addr_par | input | 1 | Even-parity bit for bus_addr |
| snoop_strobe | input | 1 | Starts a snoop cycle and qualifies bus_addr |
| addr_hold | input | 1 | Address hold given to the processor |
| mod_hit | input | 1 | Snoop hit a modified line |
| addr_strobe | input | 1 | Processor address strobe |
| mask_a20 | input | 1 | Address-mask input: clears bit 20 of the writeback address |
| par_err | output | 1 | One-cycle parity-error pulse for the snooped address |
| proto_err | output | 1 | One-cycle pulse: snoop strobe arrived while a writeback was pending |
| wb_valid | output | 1 | One-cycle pulse: wb_addr holds a new writeback address |
| wb_addr | output | 32 | Writeback physical address |

## Verification
The assertions rely on the processor giving at most one writeback per modified hit. They also rely on `mod_hit` arriving only after a snoop, never in the same cycle as the address strobe that ends a pending writeback. The bench drives every sequence in that order: snoop, then hit, then one or more idle cycles, then strobe. Any strobe it adds beyond the first is applied only once the writeback is done. Address hold changes only between those steps, never in the middle of a strobe cycle.

// File: rtl/snoop_pkg.sv
// Shared types for the snoop inquire address tracker.
package snoop_pkg;

    // Where the writeback address is taken from.
    typedef enum logic {
        SRC_BUS   = 1'b0,
        SRC_LATCH = 1'b1
    } wb_src_e;

endpackage

// File: rtl/snoop_addr_latch.sv
// Captures the snooped line address on an accepted snoop strobe and checks
// its even parity. Assumes `capture` is already qualified (not busy).
module snoop_addr_latch #(
    parameter int ADDR_W   = 32,
    parameter int LINE_LSB = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       capture,
    input  logic                       busy,
    input  logic [ADDR_W-1:LINE_LSB]   bus_addr,
    input  logic                       addr_par,
    output logic [ADDR_W-1:LINE_LSB]   lat_addr,
    output logic                       par_err
);

    localparam int LINE_W = ADDR_W - LINE_LSB;

    logic par_bad;

    // Even parity is violated when data bits and parity bit XOR to one.
    always_comb begin
        par_bad = (^bus_addr) ^ addr_par;
    end

    // Hold the line address taken at the accepted snoop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr <= '0;
        end else if (capture) begin
            lat_addr <= bus_addr;
        end
    end

    // One-cycle parity error pulse after an accepted snoop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_err <= 1'b0;
        end else begin
            par_err <= capture & par_bad;
        end
    end

    // Latched copy must not move while a writeback is outstanding.
    assert_latch_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(lat_addr))
        else $error("latched line address changed while busy");

    // Width sanity for elaboration.
    initial begin
        assert (LINE_W > 0) else $error("line address width must be positive");
    end

endmodule

// File: rtl/wb_pending_ctrl.sv
// Tracks the outstanding writeback after a modified hit, tracks whether
// address hold stayed asserted since the snoop, and flags snoops that
// arrive while a writeback is pending. Assumes at most one writeback per hit.
module wb_pending_ctrl
    import snoop_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    snoop_strobe,
    input  logic    addr_hold,
    input  logic    mod_hit,
    input  logic    addr_strobe,
    output logic    accept_snoop,
    output logic    pending,
    output logic    wb_fire,
    output wb_src_e src,
    output logic    proto_err
);

    logic hold_kept;

    // Snoops are accepted only when nothing is outstanding; writeback fires on first strobe.
    always_comb begin
        accept_snoop = snoop_strobe & ~pending;
        wb_fire      = pending & addr_strobe;
    end

    // Latched copy is valid only if hold never dropped, including this cycle.
    always_comb begin
        src = (hold_kept && addr_hold) ? SRC_LATCH : SRC_BUS;
    end

    // Pending flag: set by modified hit, cleared by the first address strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (wb_fire) begin
            pending <= 1'b0;
        end else if (mod_hit) begin
            pending <= 1'b1;
        end
    end

    // Hold tracker: armed at an accepted snoop, lost on any cycle without hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_kept <= 1'b0;
        end else if (accept_snoop) begin
            hold_kept <= addr_hold;
        end else if (!addr_hold) begin
            hold_kept <= 1'b0;
        end
    end

    // Protocol error pulse for a snoop during a pending writeback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proto_err <= 1'b0;
        end else begin
            proto_err <= snoop_strobe & pending;
        end
    end

    assert_pending_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && addr_strobe) |=> !pending)
        else $error("pending survived its address strobe");

    assert_latch_needs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_LATCH) |-> addr_hold)
        else $error("latched source chosen without address hold");

endmodule

// File: rtl/wb_addr_select.sv
// Chooses the writeback line address, applies the bit mask and registers
// the result with a one-cycle valid pulse. Assumes MASK_BIT is a line bit.
module wb_addr_select
    import snoop_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LINE_LSB = 5,
    parameter int MASK_BIT = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fire,
    input  wb_src_e                  src,
    input  logic [ADDR_W-1:LINE_LSB] lat_addr,
    input  logic [ADDR_W-1:LINE_LSB] bus_addr,
    input  logic                     mask_en,
    output logic                     wb_valid,
    output logic [ADDR_W-1:0]        wb_addr
);

    localparam int LINE_W = ADDR_W - LINE_LSB;

    logic [ADDR_W-1:LINE_LSB] line_sel;
    logic [ADDR_W-1:LINE_LSB] line_msk;
    logic [ADDR_W-1:0]        full_addr;

    // Pick latched or bus line address.
    always_comb begin
        line_sel = (src == SRC_LATCH) ? lat_addr : bus_addr;
    end

    // Clear the masked bit when the mask input is active.
    generate
        if (MASK_BIT >= LINE_LSB && MASK_BIT < ADDR_W) begin : g_mask
            always_comb begin
                line_msk = line_sel;
                if (mask_en) begin
                    line_msk[MASK_BIT] = 1'b0;
                end
            end
        end else begin : g_nomask
            always_comb begin
                line_msk = line_sel;
            end
        end
    endgenerate

    // Append the zero byte offset within the line.
    always_comb begin
        full_addr = {line_msk, {LINE_LSB{1'b0}}};
    end

    // Register the valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
        end else begin
            wb_valid <= fire;
        end
    end

    // Register the address, held between writebacks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_addr <= '0;
        end else if (fire) begin
            wb_addr <= full_addr;
        end
    end

    initial begin
        assert (LINE_W > 0) else $error("line address width must be positive");
    end

endmodule

// File: rtl/snoop_wb_tracker.sv
// Top of the snoop inquire address tracker: latches the snooped line
// address, checks parity, follows the modified-hit writeback and delivers
// the writeback address from the latch or the bus. Assumes one writeback
// per modified hit and that hit never coincides with a completing strobe.
module snoop_wb_tracker
    import snoop_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LINE_LSB = 5,
    parameter int MASK_BIT = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:LINE_LSB] bus_addr,
    input  logic                     addr_par,
    input  logic                     snoop_strobe,
    input  logic                     addr_hold,
    input  logic                     mod_hit,
    input  logic                     addr_strobe,
    input  logic                     mask_a20,
    output logic                     par_err,
    output logic                     proto_err,
    output logic                     wb_valid,
    output logic [ADDR_W-1:0]        wb_addr
);

    logic                     accept_snoop;
    logic                     pending;
    logic                     wb_fire;
    wb_src_e                  src;
    logic [ADDR_W-1:LINE_LSB] lat_addr;

    wb_pending_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .snoop_strobe (snoop_strobe),
        .addr_hold    (addr_hold),
        .mod_hit      (mod_hit),
        .addr_strobe  (addr_strobe),
        .accept_snoop (accept_snoop),
        .pending      (pending),
        .wb_fire      (wb_fire),
        .src          (src),
        .proto_err    (proto_err)
    );

    snoop_addr_latch #(
        .ADDR_W   (ADDR_W),
        .LINE_LSB (LINE_LSB)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (accept_snoop),
        .busy     (pending),
        .bus_addr (bus_addr),
        .addr_par (addr_par),
        .lat_addr (lat_addr),
        .par_err  (par_err)
    );

    wb_addr_select #(
        .ADDR_W   (ADDR_W),
        .LINE_LSB (LINE_LSB),
        .MASK_BIT (MASK_BIT)
    ) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (wb_fire),
        .src      (src),
        .lat_addr (lat_addr),
        .bus_addr (bus_addr),
        .mask_en  (mask_a20),
        .wb_valid (wb_valid),
        .wb_addr  (wb_addr)
    );

    assert_valid_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(pending && addr_strobe))
        else $error("writeback valid without pending strobe");

    assert_par_err_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> $past(snoop_strobe && !pending))
        else $error("parity error without accepted snoop");

    assert_proto_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(snoop_strobe && pending))
        else $error("protocol error without busy snoop");

    generate
        if (MASK_BIT >= LINE_LSB && MASK_BIT < ADDR_W) begin : g_mask_chk
            assert_mask_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (wb_valid && $past(mask_a20)) |-> !wb_addr[MASK_BIT])
                else $error("masked bit set in writeback address");
        end
    endgenerate

endmodule

// File: tb/snoop_wb_tracker_test.sv
module snoop_wb_tracker_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:5] bus_addr = '0;
    logic        addr_par = 1'b0;
    logic        snoop_strobe = 1'b0;
    logic        addr_hold = 1'b0;
    logic        mod_hit = 1'b0;
    logic        addr_strobe = 1'b0;
    logic        mask_a20 = 1'b0;
    logic        par_err;
    logic        proto_err;
    logic        wb_valid;
    logic [31:0] wb_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [31:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    snoop_wb_tracker uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .addr_par     (addr_par),
        .snoop_strobe (snoop_strobe),
        .addr_hold    (addr_hold),
        .mod_hit      (mod_hit),
        .addr_strobe  (addr_strobe),
        .mask_a20     (mask_a20),
        .par_err      (par_err),
        .proto_err    (proto_err),
        .wb_valid     (wb_valid),
        .wb_addr      (wb_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] expect_addr(input logic [31:5] line, input logic msk);
        logic [31:0] a;
        a = {line, 5'b0};
        if (msk) a[20] = 1'b0;
        return a;
    endfunction

    // Monitor: pop expected writebacks as the design produces them.
    always @(posedge clk) begin
        #1;
        if (rst_n && wb_valid) begin
            check("R3", {27'b0, wb_addr[4:0]}, 32'h0);
            if (exp_q.size() == 0) begin
                check("R7 unexpected valid", 32'h1, 32'h0);
            end else begin
                check("R4/R5/R6 wb_addr", wb_addr, exp_q.pop_front());
            end
        end
    end

    // Snoop cycle; checks the parity pulse and the protocol flag.
    task automatic snoop(input logic [31:5] a, input logic bad, input logic busy);
        bus_addr     = a;
        addr_par     = (^a) ^ bad;
        snoop_strobe = 1'b1;
        tick();
        snoop_strobe = 1'b0;
        check(busy ? "R9 no parity when busy" : "R2 par_err", {31'b0, par_err}, {31'b0, bad & ~busy});
        check("R9 proto_err", {31'b0, proto_err}, {31'b0, busy});
        bus_addr = ~a;
        tick();
        check("R2 par_err one cycle", {31'b0, par_err}, 32'h0);
    endtask

    // Hit, idle cycles, then the address strobe; pushes the expected address.
    task automatic writeback(input int gap, input logic [31:5] bus_val,
                             input logic [31:5] exp_line, input logic msk);
        mod_hit = 1'b1;
        tick();
        mod_hit = 1'b0;
        for (int i = 1; i < gap; i++) tick();
        bus_addr    = bus_val;
        mask_a20    = msk;
        addr_strobe = 1'b1;
        exp_q.push_back(expect_addr(exp_line, msk));
        tick();
        addr_strobe = 1'b0;
        mask_a20    = 1'b0;
        check("R7 valid pulse", {31'b0, wb_valid}, 32'h1);
        tick();
        check("R7 pulse ends", {31'b0, wb_valid}, 32'h0);
    endtask

    initial begin
        rst_n = 1'b0;
        tick();
        tick();
        check("R1 par_err", {31'b0, par_err}, 32'h0);
        check("R1 proto_err", {31'b0, proto_err}, 32'h0);
        check("R1 wb_valid", {31'b0, wb_valid}, 32'h0);
        check("R1 wb_addr", wb_addr, 32'h0);
        rst_n = 1'b1;
        tick();

        // R4 R8: hold kept, strobe two clocks after hit, bus carries junk.
        addr_hold = 1'b1;
        snoop(27'h2AB_CDEF, 1'b0, 1'b0);
        writeback(2, 27'h555_5555, 27'h2AB_CDEF, 1'b0);

        // R2: bad parity flagged; R5: hold dropped, bus address used.
        addr_hold = 1'b1;
        snoop(27'h123_4567, 1'b1, 1'b0);
        addr_hold = 1'b0;
        tick();
        addr_hold = 1'b1;
        writeback(3, 27'h0F0_F0F0, 27'h0F0_F0F0, 1'b0);

        // R5: hold low the whole time.
        addr_hold = 1'b0;
        snoop(27'h7FF_FFFF, 1'b0, 1'b0);
        writeback(2, 27'h3C3_C3C3, 27'h3C3_C3C3, 1'b0);

        // R6: mask on latched address with bit 20 set (line bit 15).
        addr_hold = 1'b1;
        snoop(27'h7FF_FFFF, 1'b0, 1'b0);
        writeback(2, 27'h000_0000, 27'h7FF_FFFF, 1'b1);

        // R6: mask on bus address.
        addr_hold = 1'b0;
        snoop(27'h001_0000, 1'b1, 1'b0);
        writeback(2, 27'h00F_8000, 27'h00F_8000, 1'b1);

        // R7: strobe with nothing pending gives no pulse.
        addr_strobe = 1'b1;
        tick();
        addr_strobe = 1'b0;
        check("R7 no pulse without hit", {31'b0, wb_valid}, 32'h0);

        // R9: snoop while pending is ignored; R10: second strobe has no effect.
        addr_hold = 1'b1;
        snoop(27'h246_8ACE, 1'b0, 1'b0);
        mod_hit = 1'b1;
        tick();
        mod_hit = 1'b0;
        snoop(27'h135_7BDF, 1'b1, 1'b1);
        bus_addr    = 27'h111_1111;
        addr_strobe = 1'b1;
        exp_q.push_back(expect_addr(27'h246_8ACE, 1'b0));
        tick();
        addr_strobe = 1'b0;
        check("R9 valid after ignored snoop", {31'b0, wb_valid}, 32'h1);
        tick();
        addr_strobe = 1'b1;
        tick();
        addr_strobe = 1'b0;
        check("R10 second strobe ignored", {31'b0, wb_valid}, 32'h0);
        tick();
        check("R10 wb_addr held", wb_addr, expect_addr(27'h246_8ACE, 1'b0));

        tick();
        check("R7 all writebacks seen", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule